// File: doc/BRIEF.md
# Serial Analog Mux Command Receiver

This block takes short serial command frames from a timing engine and turns them into control levels for an analog front end. The controls are a channel select for the front-end multiplexer and one sample/hold level for each of several sample-and-hold pairs. The serial clock, serial data and enable arrive from another domain. They are resampled in a faster system clock, and edges of the serial clock are detected there.

Fields are not applied together at the end of the frame. The sample/hold levels change on the falling edge of an early serial clock in the frame, so the held signals are frozen before the multiplexer moves. The channel select changes only on the falling edge of the last clock, which is also when a one-cycle completion pulse is raised. Driving the enable low throws away any partial frame and returns the receiver to its start state.

Top module: `amux_cmd_rx`

## Requirements
- R1: After reset, `mux_sel`, `hold`, `frame_status` and `frame_done` are all 0.
- R2: A frame has 8 bits and is sent most significant bit first. Bit 7 is a status bit, bit 6 drives `hold[2]`, bit 5 drives `hold[1]`, bit 4 drives `hold[0]`, and bits 3:0 form the channel select.
- R3: A `hold` bit of 0 means sample and 1 means hold. `hold` takes its new value after the falling edge of the 4th serial clock in the frame. At that point `mux_sel` still shows the previous frame's value.
- R4: `mux_sel` takes frame bits 3:0 after the falling edge of the 8th serial clock, and at no other time.
- R5: `frame_done` is high for exactly one system clock per complete frame, in the cycle after the 8th falling edge is seen.
- R6: `frame_status` takes frame bit 7 at the end of the frame and drives no other output.
- R7: Driving `en` low discards a partial frame. Outputs already applied keep their values, and the next frame after `en` returns high is decoded from its first bit.
- R8: While `en` is low, serial clock edges change no output and raise no `frame_done`.
- R9: `sclk`, `sdata` and `en` each pass through a synchronizer of at least two flops. Data is taken on the rising serial clock edge, so an output moves no earlier than the second system clock after the serial clock edge that causes the change.
- R10: Frames may follow each other with no gap. The bit count restarts after every 8th falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the timing engine |
| sdata | input | 1 | Serial data, valid on the rising serial clock edge |
| en | input | 1 | Receiver enable; low clears the frame state |
| mux_sel | output | 4 | Front-end multiplexer channel select |
| hold | output | 3 | Sample (0) / hold (1) level for each pair |
| frame_status | output | 1 | Status bit of the last complete frame |
| frame_done | output | 1 | One-cycle pulse when a frame completes |

## Verification
The bench uses the default parameters: a 4-bit select, three hold pairs and a two-flop synchronizer, which gives the 8-bit frame. With these values, every hold pattern and every select value appear in random frames. Each bit of the frame maps to a distinct output, so a swapped bit order shows up. With the short synchronizer the bench can also probe the exact system clock in which the 4th-edge hold update appears. Directed cases cover frames aborted before and after the hold update, clock toggles while disabled, and back-to-back frames.

// File: rtl/amux_cmd_rx.sv
module amux_cmd_rx #(
  parameter int SEL_W  = 4,
  parameter int HOLD_N = 3,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              en,
  output logic [SEL_W-1:0]  mux_sel,
  output logic [HOLD_N-1:0] hold,
  output logic              frame_status,
  output logic              frame_done
);
  localparam int FRAME_BITS = SEL_W + HOLD_N + 1;
  localparam int HOLD_EDGE  = HOLD_N + 1;
  localparam int CW         = $clog2(FRAME_BITS + 1);

  logic [SYNC_N-1:0]     sck_sy, dat_sy, en_sy;
  logic                  sck_q;
  logic [FRAME_BITS-1:0] shreg;
  logic [CW-1:0]         nfall;

  wire sck  = sck_sy[SYNC_N-1];
  wire dat  = dat_sy[SYNC_N-1];
  wire en_s = en_sy[SYNC_N-1];
  wire rise = en_s &  sck & ~sck_q;
  wire fall = en_s & ~sck &  sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      dat_sy <= '0;
      en_sy  <= '0;
      sck_q  <= 1'b0;
    end else begin
      sck_sy <= {sck_sy[SYNC_N-2:0], sclk};
      dat_sy <= {dat_sy[SYNC_N-2:0], sdata};
      en_sy  <= {en_sy[SYNC_N-2:0], en};
      sck_q  <= sck;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg        <= '0;
      nfall        <= '0;
      hold         <= '0;
      mux_sel      <= '0;
      frame_status <= 1'b0;
      frame_done   <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (!en_s) begin
        shreg <= '0;
        nfall <= '0;
      end else begin
        if (rise) shreg <= {shreg[FRAME_BITS-2:0], dat};
        if (fall) begin
          if (nfall == CW'(HOLD_EDGE - 1)) hold <= shreg[HOLD_N-1:0];
          if (nfall == CW'(FRAME_BITS - 1)) begin
            mux_sel      <= shreg[SEL_W-1:0];
            frame_status <= shreg[FRAME_BITS-1];
            frame_done   <= 1'b1;
            nfall        <= '0;
          end else begin
            nfall <= nfall + 1'b1;
          end
        end
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R5
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (!frame_done && $stable(hold) && $stable(mux_sel))); // R8
  AST_MUX_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mux_sel) |-> frame_done); // R4
  AST_HOLD_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hold) |-> (nfall == CW'(HOLD_EDGE))); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    nfall < CW'(FRAME_BITS)); // R10
endmodule

// File: tb/sim_amux_cmd_rx.sv
module sim_amux_cmd_rx;
  localparam int HP = 8;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sdata = 1'b0, en = 1'b0;
  logic [3:0] mux_sel;
  logic [2:0] hold;
  logic frame_status, frame_done;
  int nchk = 0, nbad = 0, ndone = 0, ndone_cyc = 0;
  logic [3:0] e_mux = '0;
  logic [2:0] e_hold = '0;
  logic e_stat = 1'b0;
  logic done_q = 1'b0;

  always #2 clk = ~clk;

  amux_cmd_rx u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .en(en),
    .mux_sel(mux_sel), .hold(hold), .frame_status(frame_status), .frame_done(frame_done));

  always @(posedge clk) begin
    if (frame_done) ndone_cyc++;
    if (frame_done && !done_q) ndone++;
    done_q <= frame_done;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] f_hold(input logic [7:0] f); return f[6:4]; endfunction
  function automatic logic [3:0] f_mux(input logic [7:0] f);  return f[3:0]; endfunction

  // sends the first n bits of f MSB first, checking as it goes
  task automatic send(input logic [7:0] f, input int n);
    int d0, c0;
    d0 = ndone; c0 = ndone_cyc;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sdata = f[7-i];
      repeat (HP) @(negedge clk); sclk = 1'b1;
      repeat (HP) @(negedge clk); sclk = 1'b0;
      if (i == 3) begin
        e_hold = f_hold(f);
        repeat (6) @(negedge clk);
        chk("R3 hold after 4th fall", hold, e_hold);
        chk("R3 mux unchanged mid-frame", mux_sel, e_mux);
      end
      if (i == 7) begin
        e_mux = f_mux(f); e_stat = f[7];
        repeat (6) @(negedge clk);
        chk("R4 mux_sel", mux_sel, e_mux);
        chk("R6 status", frame_status, e_stat);
        chk("R2 hold field", hold, e_hold);
        chk("R5 one done pulse", ndone - d0, 1);
        chk("R5 done width", ndone_cyc - c0, 1);
      end
    end
    if (n < 8) chk("R7 no done for partial", ndone - d0, 0);
  endtask

  initial begin
    int d0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 mux reset", mux_sel, 0);
    chk("R1 hold reset", hold, 0);
    chk("R1 status reset", frame_status, 0);
    chk("R1 done reset", frame_done, 0);
    rst_n = 1'b1; en = 1'b1;
    repeat (4) @(negedge clk);

    send(8'hFF, 8);  // R2
    send(8'h00, 8);  // R10 back to back
    send(8'hA5, 8);
    send(8'h5A, 8);

    // R9: hold must not move in the first system clock after the 4th fall
    send(8'h00, 8);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); sdata = (i == 1 || i == 2 || i == 3);
      repeat (HP) @(negedge clk); sclk = 1'b1;
      repeat (HP) @(negedge clk); sclk = 1'b0;
    end
    @(negedge clk);
    chk("R9 sync latency", hold, 3'b000);
    repeat (6) @(negedge clk);
    chk("R9 hold after sync", hold, 3'b111);
    e_hold = 3'b111;
    en = 1'b0; repeat (6) @(negedge clk); en = 1'b1; repeat (6) @(negedge clk);

    for (int k = 0; k < 40; k++) send(8'($urandom), 8);  // R2

    // R7: abort before and after the hold update
    send(8'h3C, 8);
    send(8'hFF, 3);
    en = 1'b0; repeat (6) @(negedge clk);
    chk("R7 hold kept", hold, e_hold);
    chk("R7 mux kept", mux_sel, e_mux);
    en = 1'b1; repeat (6) @(negedge clk);
    send(8'h96, 8);
    send(8'hE1, 6);
    en = 1'b0; repeat (6) @(negedge clk);
    chk("R7 mux kept late abort", mux_sel, e_mux);
    en = 1'b1; repeat (6) @(negedge clk);
    send(8'h42, 8);

    // R8: clock toggles while disabled
    en = 1'b0; repeat (6) @(negedge clk);
    d0 = ndone;
    for (int i = 0; i < 8; i++) begin
      sdata = 1'b1;
      repeat (HP) @(negedge clk); sclk = 1'b1;
      repeat (HP) @(negedge clk); sclk = 1'b0;
    end
    repeat (6) @(negedge clk);
    chk("R8 hold unchanged", hold, e_hold);
    chk("R8 mux unchanged", mux_sel, e_mux);
    chk("R8 status unchanged", frame_status, e_stat);
    chk("R8 no done", ndone - d0, 0);
    en = 1'b1; repeat (6) @(negedge clk);
    send(8'h7B, 8);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule